// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Result Memory

This block is the digital control core of a four-channel simultaneous-sampling acquisition front end. A host sets a run length of one to four channels, and an input bank, by writing over a small parallel bus made of a chip select, a write strobe and four address lines. The configuration is carried on the address lines.

Each accepted start pulse freezes every channel's input word at the same instant. The block then converts the frozen channels one after another, always starting from channel 0. Each conversion is modelled as a fixed busy interval of `CONV_CYC` clocks. The result of each conversion is written into a four-word result memory. When the last conversion of the run completes, a single interrupt is raised. Read strobes then return the stored words in channel order, and an internal pointer advances on every strobe.

Top module: `daq_seq_top`

## Requirements
- R1: After synchronous reset, `busy`, `irq`, `bank_b` and `rd_data` are 0, every memory word is 0, and the run length is one channel.
- R2: A write (`cs` and `wr` high in the same cycle) with `addr[3]`=0 sets the run length to `addr[1:0]`+1 and sets `bank_b` to `addr[2]`. A write with `addr[3]`=1 changes nothing. The setting stays in force until the next accepted write.
- R3: A start pulse sampled while idle makes `busy` high from the next cycle. All channel words on `ch_in` (channel k in bits `k*14 +: 14`) are captured at that edge, and later changes on `ch_in` do not alter the run's results.
- R4: Each conversion lasts `CONV_CYC` (48) cycles. For a run of N channels, `busy` stays high for exactly 48·N cycles, and `irq` rises in the same cycle that `busy` falls, never earlier.
- R5: At the end of a run, memory words 0 to N-1 hold the captured words of channels 0 to N-1. Words N to 3 keep their previous contents.
- R6: A start pulse sampled while `busy` is high is ignored. It changes neither the run length, nor the captured data, nor the stored results.
- R7: A read (`cs` and `rd` high in the same cycle) loads `rd_data` with the memory word at the read pointer in the next cycle, then advances the pointer modulo 4. Without a read, `rd_data` holds its value.
- R8: The first read after a run clears `irq`. `irq` then stays low until the next run ends.
- R9: An accepted start pulse resets the read pointer to word 0 and clears `irq`.
- R10: A configuration write made during a run does not change that run's length. It applies from the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus chip select |
| wr | input | 1 | Configuration write strobe |
| rd | input | 1 | Result read strobe |
| addr | input | 4 | Configuration word carried on the address lines |
| start | input | 1 | Start-of-run pulse |
| ch_in | input | 56 | Four packed 14-bit channel input words |
| rd_data | output | 14 | Last word read from the result memory |
| irq | output | 1 | End-of-run interrupt |
| busy | output | 1 | Run in progress |
| bank_b | output | 1 | Selected input bank |

## Verification
Counting from the edge that samples a start pulse:
- `busy` is due one cycle after that edge.
- `irq` and the fall of `busy` are due exactly 48·N edges after it.

The bench samples one cycle before that point, expecting `busy` high and `irq` low, and then at that point, expecting the reverse.

Reads, writes and mid-run start pulses are driven on falling edges. Each result is checked at the falling edge that follows the single rising edge that registered it. The rules are that `rd_data` and `irq` change one cycle after a read, and `bank_b` changes one cycle after a write.

// File: rtl/daq_seq_pkg.sv
package daq_seq_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = 4;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_CONV
    } seq_state_e;

    typedef struct packed {
        logic            bank_b;
        logic [CH_W-1:0] last_ch;
    } seq_cfg_t;

    function automatic logic cfg_hit(input logic [ADDR_W-1:0] a);
        return (a[3] == 1'b0);
    endfunction

    function automatic seq_cfg_t cfg_decode(input logic [ADDR_W-1:0] a);
        seq_cfg_t c;
        c.bank_b  = a[2];
        c.last_ch = a[CH_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/daq_cfg_reg.sv
module daq_cfg_reg
    import daq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output seq_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en && cfg_hit(addr)) begin
            cfg <= cfg_decode(addr);
        end
    end

endmodule

// File: rtl/daq_conv_seq.sv
module daq_conv_seq
    import daq_seq_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int CONV_CYC = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CH_W-1:0]          cfg_last,
    input  logic [NUM_CH*DATA_W-1:0] ch_in,
    output logic                     busy,
    output logic                     start_acc,
    output logic [CH_W-1:0]          run_last,
    output logic                     res_we,
    output logic [CH_W-1:0]          res_idx,
    output logic [DATA_W-1:0]        res_data,
    output logic                     run_done
);

    localparam int CNT_W = $clog2(CONV_CYC);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYC - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] hold [NUM_CH];

    assign busy      = (state == SEQ_CONV);
    assign start_acc = start && (state == SEQ_IDLE);
    assign res_we    = busy && (cnt == LAST_CNT);
    assign res_idx   = ch;
    assign res_data  = hold[ch];
    assign run_done  = res_we && (ch == run_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            cnt      <= '0;
            ch       <= '0;
            run_last <= '0;
            for (int i = 0; i < NUM_CH; i++) hold[i] <= '0;
        end else if (state == SEQ_IDLE) begin
            if (start) begin
                state    <= SEQ_CONV;
                cnt      <= '0;
                ch       <= '0;
                run_last <= cfg_last;
                for (int i = 0; i < NUM_CH; i++) hold[i] <= ch_in[i*DATA_W +: DATA_W];
            end
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
            if (ch == run_last) state <= SEQ_IDLE;
            else                ch    <= ch + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/daq_result_port.sv
module daq_result_port
    import daq_seq_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_we,
    input  logic [CH_W-1:0]   res_idx,
    input  logic [DATA_W-1:0] res_data,
    input  logic              run_done,
    input  logic              start_acc,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [DATA_W-1:0] mem [NUM_CH];
    logic [CH_W-1:0]   ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
        end else if (res_we) begin
            mem[res_idx] <= res_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            rd_data <= '0;
            irq     <= 1'b0;
        end else begin
            if (rd_stb) rd_data <= mem[ptr];
            if (start_acc)   ptr <= '0;
            else if (rd_stb) ptr <= ptr + 1'b1;
            if (start_acc)     irq <= 1'b0;
            else if (run_done) irq <= 1'b1;
            else if (rd_stb)   irq <= 1'b0;
        end
    end

endmodule

// File: rtl/daq_seq_top.sv
module daq_seq_top
    import daq_seq_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int CONV_CYC = 48
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     start,
    input  logic [NUM_CH*DATA_W-1:0] ch_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     irq,
    output logic                     busy,
    output logic                     bank_b
);

    seq_cfg_t          cfg;
    logic              start_acc;
    logic [CH_W-1:0]   run_last;
    logic              res_we;
    logic [CH_W-1:0]   res_idx;
    logic [DATA_W-1:0] res_data;
    logic              run_done;

    assign bank_b = cfg.bank_b;

    daq_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cs && wr),
        .addr  (addr),
        .cfg   (cfg)
    );

    daq_conv_seq #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_last  (cfg.last_ch),
        .ch_in     (ch_in),
        .busy      (busy),
        .start_acc (start_acc),
        .run_last  (run_last),
        .res_we    (res_we),
        .res_idx   (res_idx),
        .res_data  (res_data),
        .run_done  (run_done)
    );

    daq_result_port #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .res_we    (res_we),
        .res_idx   (res_idx),
        .res_data  (res_data),
        .run_done  (run_done),
        .start_acc (start_acc),
        .rd_stb    (cs && rd),
        .rd_data   (rd_data),
        .irq       (irq)
    );

endmodule

// File: rtl/daq_seq_checker.sv
module daq_seq_checker
    import daq_seq_pkg::*;
#(
    parameter int DATA_W   = 14,
    parameter int CONV_CYC = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rd,
    input logic              start,
    input logic              busy,
    input logic              irq,
    input logic [DATA_W-1:0] rd_data,
    input logic [CH_W-1:0]   run_last
);

    logic [31:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= '0;
    end

    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_run_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (bcnt == CONV_CYC * (32'(run_last) + 1)));

    p_irq_at_end_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(busy) && !busy));

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |=> $stable(rd_data));

    p_rd_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && !busy) |=> !irq);

    p_irq_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cs && rd) && !start) |=> irq);

    p_start_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !irq);

endmodule

bind daq_seq_top daq_seq_checker #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .rd       (rd),
    .start    (start),
    .busy     (busy),
    .irq      (irq),
    .rd_data  (rd_data),
    .run_last (run_last)
);

// File: tb/daq_seq_top_bench.sv
module daq_seq_top_bench;

    localparam int DW   = 14;
    localparam int NCH  = 4;
    localparam int CONV = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, wr = 1'b0, rd = 1'b0, start = 1'b0;
    logic [3:0]    addr = '0;
    logic [NCH*DW-1:0] ch_in = '0;
    logic [DW-1:0] rd_data;
    logic          irq, busy, bank_b;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] m_mem [NCH];
    int            m_len = 1;
    logic          m_bank = 1'b0;
    int            m_ptr = 0;

    always #4 clk = ~clk;

    daq_seq_top u_daq_seq_top (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .start(start), .ch_in(ch_in), .rd_data(rd_data), .irq(irq),
        .busy(busy), .bank_b(bank_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] rand_words();
        logic [NCH*DW-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*DW +: DW] = DW'($urandom);
        return v;
    endfunction

    function automatic int len_of(input logic [3:0] a, input int cur);
        return a[3] ? cur : int'(a[1:0]) + 1;
    endfunction

    task automatic bus_write(input logic [3:0] a);
        @(negedge clk); cs = 1; wr = 1; addr = a;
        @(posedge clk);
        @(negedge clk); cs = 0; wr = 0;
        if (!a[3]) begin m_len = len_of(a, m_len); m_bank = a[2]; end
        check("R2 bank", 32'(bank_b), 32'(m_bank));
    endtask

    task automatic bus_read(input bit first);
        @(negedge clk); cs = 1; rd = 1;
        @(posedge clk);
        @(negedge clk); cs = 0; rd = 0;
        check("R7 rd_data", 32'(rd_data), 32'(m_mem[m_ptr]));
        m_ptr = (m_ptr + 1) % NCH;
        if (first) check("R8 irq cleared", 32'(irq), 0);
    endtask

    // one run; inj: start pulse mid-run (R6); wcfg: config write mid-run (R10)
    task automatic run(input bit inj, input bit wcfg, input logic [3:0] wa);
        logic [NCH*DW-1:0] cap;
        int n;
        n   = m_len;
        cap = rand_words();
        @(negedge clk); start = 1; ch_in = cap;
        @(posedge clk);
        @(negedge clk); start = 0; ch_in = rand_words();
        check("R3 busy rises", 32'(busy), 1);
        check("R9 irq cleared by start", 32'(irq), 0);
        m_ptr = 0;
        for (int c = 1; c < CONV * n; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (inj && c == 10) begin start = 1; ch_in = rand_words(); end
            if (c == 11) start = 0;
            if (wcfg && c == 20) begin cs = 1; wr = 1; addr = wa; end
            if (c == 21) begin
                cs = 0; wr = 0;
                if (wcfg && !wa[3]) begin m_len = len_of(wa, m_len); m_bank = wa[2]; end
            end
        end
        check("R4 busy before end", 32'(busy), 1);
        check("R4 irq not early", 32'(irq), 0);
        @(posedge clk);
        @(negedge clk);
        check("R4 irq at end", 32'(irq), 1);
        check("R4 busy falls", 32'(busy), 0);
        for (int i = 0; i < n; i++) m_mem[i] = cap[i*DW +: DW];
    endtask

    initial begin
        process::self().srandom(32'h5eed_0042);
        for (int i = 0; i < NCH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check("R1 busy", 32'(busy), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 bank_b", 32'(bank_b), 0);
        check("R1 rd_data", 32'(rd_data), 0);
        // R1: default one-channel run
        run(0, 0, 4'h0);
        bus_read(1);
        bus_read(0);   // R5: word 1 untouched, still reset value
        // R2: ignored write then accepted writes
        bus_write(4'b1111);
        bus_write(4'b0111);
        run(1, 0, 4'h0);   // R6 start ignored
        for (int k = 0; k < 5; k++) bus_read(k == 0);   // R7 wrap
        // R10: write during run
        bus_write(4'b0001);
        run(0, 1, 4'b0011);
        bus_read(1);
        run(0, 0, 4'h0);   // R9: pointer reset from mid position
        bus_read(1);
        bus_read(0);
        for (int t = 0; t < 20; t++) begin
            logic [3:0] a;
            a = 4'($urandom);
            if ($urandom_range(0, 1) == 1) bus_write(a);
            run($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, 4'($urandom));
            for (int k = 0, nr = $urandom_range(0, 5); k < nr; k++) bus_read(k == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule